// File: doc/BRIEF.md
# Pipeline Hazard Scoreboard

This block keeps an ordered record of the destination registers that belong to instructions still in flight in a short in-order pipeline. The decode stage records an instruction's destination when it issues. The decode stage also checks its two source registers and its own destination against the record. If any of the three checks reports a match, decode holds the instruction back. This covers both read-after-write and write-after-write hazards.

Entries leave the record strictly oldest first. One remove is issued for every instruction that leaves the back of the pipeline, including instructions that were discarded. The caller must line the remove up with that instruction's register-file write, and the searches with the register-file reads. A remove and an insert may happen in the same cycle. In that case the remove acts first: the searches no longer see the retiring entry, and the insert is accepted even when the record was full.

The depth and the register-index width are parameters. With the default depth of two, the block suits a three-stage pipeline.

Top module: `hazard_scoreboard`

## Requirements
- R1: A synchronous active-high reset empties the scoreboard. After the reset edge `empty`=1, `full`=0 and `rem_err`=0, and no search port reports a hit.
- R2: Each search port reports a hit when its argument is valid and equals the valid destination index of an entry still held. The three ports work independently in the same cycle.
- R3: `full` is 1 when DEPTH entries are held. An insert while full, with no remove in the same cycle, is dropped: its index never matches, and the held entries are unchanged.
- R4: An insert with an invalid destination occupies a slot and counts toward `full`, but it never produces a hit.
- R5: A search whose argument valid bit is 0 never reports a hit, whatever the entries hold.
- R6: A remove retires the oldest held entry. Its index stops matching, and younger entries keep matching.
- R7: With remove and insert in one cycle, the search results of that cycle exclude the retiring entry. The insert is accepted even when the scoreboard was full, so `full` stays 1.
- R8: A remove while empty changes nothing. `rem_err` is 1 in the cycle after it, for one cycle only.
- R9: `full` and `empty` are registered. They reflect an insert or remove from the clock edge that ends its cycle onward.
- R10: Search results are combinational on the current contents. An insert in the same cycle is not visible to the searches until the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Record one issuing instruction |
| ins_dst_vld | input | 1 | The issuing instruction writes a register |
| ins_dst_idx | input | IDX_W | Destination index of the issuing instruction |
| rem_valid | input | 1 | Retire the oldest entry |
| s1_vld | input | 1 | First source present |
| s1_idx | input | IDX_W | First source index |
| s2_vld | input | 1 | Second source present |
| s2_idx | input | IDX_W | Second source index |
| s3_vld | input | 1 | Destination present (write-after-write check) |
| s3_idx | input | IDX_W | Destination index to check |
| hit1 | output | 1 | First source is pending |
| hit2 | output | 1 | Second source is pending |
| hit3 | output | 1 | Destination is pending |
| full | output | 1 | DEPTH entries held (registered) |
| empty | output | 1 | No entries held (registered) |
| rem_err | output | 1 | Pulse: the previous cycle removed from an empty scoreboard |

## Verification
The hardest situation to reach is a remove and an insert in the same cycle while the record is full, with the new index equal to the index being retired. Here the search must miss in that cycle and hit in the next. The vector table gets there by filling both slots, then swapping one entry for another, then swapping the head for an entry with the same index. Before and after the swap it probes that index on all three ports, with valid and invalid arguments. A dropped insert into a full record is exposed later, once the record has drained below full, by searching for the index that was dropped.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    SB_HOLD = 2'b00,
    SB_PUSH = 2'b01,
    SB_POP  = 2'b10,
    SB_SWAP = 2'b11
  } sb_op_e;
endpackage

// File: rtl/sb_ptr_ctrl.sv
module sb_ptr_ctrl #(
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             push_ok,
  output logic             pop_ok,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] cnt,
  output logic             full_q,
  output logic             empty_q,
  output logic             rem_err_q
);
  import sb_pkg::*;

  sb_op_e           op;
  logic [CNT_W-1:0] cnt_n;

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // The remove is decided first; a granted remove frees a slot for the insert.
  assign pop_ok  = pop_req && (cnt != '0);
  assign push_ok = push_req && ((cnt != CNT_W'(DEPTH)) || pop_ok);
  assign op      = sb_op_e'({pop_ok, push_ok});

  always_comb begin
    unique case (op)
      SB_PUSH: cnt_n = cnt + 1'b1;
      SB_POP:  cnt_n = cnt - 1'b1;
      default: cnt_n = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head      <= '0;
      tail      <= '0;
      cnt       <= '0;
      full_q    <= 1'b0;
      empty_q   <= 1'b1;
      rem_err_q <= 1'b0;
    end else begin
      if (pop_ok)  head <= wrap_inc(head);
      if (push_ok) tail <= wrap_inc(tail);
      cnt       <= cnt_n;
      full_q    <= (cnt_n == CNT_W'(DEPTH));
      empty_q   <= (cnt_n == '0);
      rem_err_q <= pop_req && (cnt == '0);
    end
  end
endmodule

// File: rtl/sb_entry_store.sv
module sb_entry_store #(
  parameter int DEPTH = 2,
  parameter int IDX_W = 5,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [PTR_W-1:0]       waddr,
  input  logic                   wvld,
  input  logic [IDX_W-1:0]       widx,
  output logic [DEPTH-1:0]       ent_vld,
  output logic [DEPTH*IDX_W-1:0] ent_idx
);
  logic [IDX_W-1:0] mem_idx [DEPTH];
  logic [DEPTH-1:0] mem_vld;

  // Storage holds no reset; occupancy is tracked by the pointer control.
  always_ff @(posedge clk) begin
    if (we) begin
      mem_idx[waddr] <= widx;
      mem_vld[waddr] <= wvld;
    end
  end

  assign ent_vld = mem_vld;

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign ent_idx[g*IDX_W +: IDX_W] = mem_idx[g];
  end
endmodule

// File: rtl/sb_match.sv
module sb_match #(
  parameter int DEPTH = 2,
  parameter int IDX_W = 5
) (
  input  logic [DEPTH-1:0]       live,
  input  logic [DEPTH*IDX_W-1:0] ent_idx,
  input  logic                   q_vld,
  input  logic [IDX_W-1:0]       q_idx,
  output logic                   hit
);
  logic any;

  always_comb begin
    any = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      any = any | (live[i] && (ent_idx[i*IDX_W +: IDX_W] == q_idx));
    end
    hit = q_vld && any;
  end
endmodule

// File: rtl/hazard_scoreboard.sv
module hazard_scoreboard #(
  parameter int DEPTH = 2,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_valid,
  input  logic             ins_dst_vld,
  input  logic [IDX_W-1:0] ins_dst_idx,
  input  logic             rem_valid,
  input  logic             s1_vld,
  input  logic [IDX_W-1:0] s1_idx,
  input  logic             s2_vld,
  input  logic [IDX_W-1:0] s2_idx,
  input  logic             s3_vld,
  input  logic [IDX_W-1:0] s3_idx,
  output logic             hit1,
  output logic             hit2,
  output logic             hit3,
  output logic             full,
  output logic             empty,
  output logic             rem_err
);
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int NPORTS = 3;

  logic                   push_ok, pop_ok;
  logic [PTR_W-1:0]       head, tail;
  logic [CNT_W-1:0]       cnt;
  logic [DEPTH-1:0]       ent_vld, live;
  logic [DEPTH*IDX_W-1:0] ent_idx;
  logic [NPORTS-1:0]      q_vld, hits;
  logic [IDX_W-1:0]       q_idx [NPORTS];

  sb_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst),
    .push_req(ins_valid), .pop_req(rem_valid),
    .push_ok(push_ok), .pop_ok(pop_ok),
    .head(head), .tail(tail), .cnt(cnt),
    .full_q(full), .empty_q(empty), .rem_err_q(rem_err)
  );

  sb_entry_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk(clk), .we(push_ok), .waddr(tail),
    .wvld(ins_dst_vld), .widx(ins_dst_idx),
    .ent_vld(ent_vld), .ent_idx(ent_idx)
  );

  // A slot is searchable if it is occupied, holds a real destination,
  // and is not the head being retired in this very cycle.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int off;
      off = (i >= int'(head)) ? (i - int'(head)) : (i + DEPTH - int'(head));
      live[i] = (off < int'(cnt)) && ent_vld[i] &&
                !(pop_ok && (PTR_W'(i) == head));
    end
  end

  assign q_vld    = {s3_vld, s2_vld, s1_vld};
  assign q_idx[0] = s1_idx;
  assign q_idx[1] = s2_idx;
  assign q_idx[2] = s3_idx;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    sb_match #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_match (
      .live(live), .ent_idx(ent_idx),
      .q_vld(q_vld[p]), .q_idx(q_idx[p]),
      .hit(hits[p])
    );
  end

  assign hit1 = hits[0];
  assign hit2 = hits[1];
  assign hit3 = hits[2];
endmodule

// File: rtl/sb_checker.sv
module sb_checker (
  input logic clk,
  input logic rst,
  input logic ins_valid,
  input logic rem_valid,
  input logic s1_vld,
  input logic s2_vld,
  input logic s3_vld,
  input logic hit1,
  input logic hit2,
  input logic hit3,
  input logic full,
  input logic empty,
  input logic rem_err
);
  p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (full && ins_valid && !rem_valid) |=> full);

  p_swap_keeps_full_r7: assert property (@(posedge clk) disable iff (rst)
    (full && ins_valid && rem_valid) |=> full);

  p_empty_remove_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (empty && rem_valid) |=> (rem_err && empty));

  p_err_needs_remove_r8: assert property (@(posedge clk) disable iff (rst)
    (!rem_valid) |=> !rem_err);

  p_idle_stays_empty_r1: assert property (@(posedge clk) disable iff (rst)
    (empty && !ins_valid) |=> empty);

  p_invalid_arg_r5: assert property (@(posedge clk) disable iff (rst)
    ((!s1_vld |-> !hit1) and (!s2_vld |-> !hit2) and (!s3_vld |-> !hit3)));

  p_no_hit_when_empty_r2: assert property (@(posedge clk) disable iff (rst)
    empty |-> !(hit1 || hit2 || hit3));
endmodule

bind hazard_scoreboard sb_checker u_chk (
  .clk(clk), .rst(rst), .ins_valid(ins_valid), .rem_valid(rem_valid),
  .s1_vld(s1_vld), .s2_vld(s2_vld), .s3_vld(s3_vld),
  .hit1(hit1), .hit2(hit2), .hit3(hit3),
  .full(full), .empty(empty), .rem_err(rem_err)
);

// File: tb/sim_hazard_scoreboard.sv
module sim_hazard_scoreboard;
  localparam int IDX_W = 5;
  localparam int NROWS = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ins_valid = 1'b0, ins_dst_vld = 1'b0, rem_valid = 1'b0;
  logic [IDX_W-1:0] ins_dst_idx = '0;
  logic s1_vld = 1'b0, s2_vld = 1'b0, s3_vld = 1'b0;
  logic [IDX_W-1:0] s1_idx = '0, s2_idx = '0, s3_idx = '0;
  logic hit1, hit2, hit3, full, empty, rem_err;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  hazard_scoreboard #(.DEPTH(2), .IDX_W(IDX_W)) u0 (.*);

  // Row: ins_v, ins_dv, ins_idx, rem, s1v, s1i, s2v, s2i, s3v, s3i,
  //      expected {hit1,hit2,hit3}, expected {full,empty} before the edge
  localparam logic [30:0] TBL [NROWS] = '{
    {1'b1,1'b1,5'd5, 1'b0, 1'b1,5'd5,  1'b0,5'd0,  1'b0,5'd0,  3'b000, 2'b01},
    {1'b1,1'b0,5'd7, 1'b0, 1'b1,5'd5,  1'b1,5'd7,  1'b0,5'd0,  3'b100, 2'b00},
    {1'b1,1'b1,5'd9, 1'b0, 1'b1,5'd9,  1'b1,5'd7,  1'b1,5'd5,  3'b001, 2'b10},
    {1'b0,1'b0,5'd0, 1'b1, 1'b1,5'd5,  1'b0,5'd5,  1'b1,5'd5,  3'b000, 2'b10},
    {1'b0,1'b0,5'd0, 1'b0, 1'b1,5'd5,  1'b1,5'd9,  1'b1,5'd7,  3'b000, 2'b00},
    {1'b1,1'b1,5'd3, 1'b0, 1'b1,5'd3,  1'b0,5'd0,  1'b0,5'd0,  3'b000, 2'b00},
    {1'b1,1'b1,5'd12,1'b1, 1'b1,5'd3,  1'b1,5'd12, 1'b1,5'd7,  3'b100, 2'b10},
    {1'b0,1'b0,5'd0, 1'b0, 1'b1,5'd12, 1'b1,5'd3,  1'b1,5'd12, 3'b111, 2'b10},
    {1'b1,1'b1,5'd3, 1'b1, 1'b1,5'd3,  1'b1,5'd12, 1'b0,5'd0,  3'b010, 2'b10},
    {1'b0,1'b0,5'd0, 1'b0, 1'b1,5'd3,  1'b1,5'd12, 1'b0,5'd3,  3'b110, 2'b10},
    {1'b0,1'b0,5'd0, 1'b1, 1'b1,5'd3,  1'b1,5'd12, 1'b0,5'd0,  3'b100, 2'b10},
    {1'b0,1'b0,5'd0, 1'b1, 1'b1,5'd3,  1'b0,5'd0,  1'b0,5'd0,  3'b000, 2'b00},
    {1'b0,1'b0,5'd0, 1'b0, 1'b1,5'd3,  1'b0,5'd0,  1'b0,5'd0,  3'b000, 2'b01}
  };

  function automatic string row_tag(input int r);
    case (r)
      0:  return "R10 R9";
      1:  return "R2 R4";
      2:  return "R3 R4";
      3:  return "R7 R5";
      4:  return "R3 R4";
      5:  return "R10";
      6:  return "R7";
      7:  return "R2";
      8:  return "R7 R6";
      9:  return "R5";
      10: return "R6";
      11: return "R6 R9";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 reset flags {full,empty,rem_err}", {29'd0, full, empty, rem_err}, 32'b010);
    check("R1 reset hits", {29'd0, hit1, hit2, hit3}, 32'd0);

    for (int r = 0; r < NROWS; r++) begin
      @(negedge clk);
      {ins_valid, ins_dst_vld, ins_dst_idx, rem_valid,
       s1_vld, s1_idx, s2_vld, s2_idx, s3_vld, s3_idx} = TBL[r][30:5];
      #1;
      check($sformatf("%s row %0d hits", row_tag(r), r),
            {29'd0, hit1, hit2, hit3}, {29'd0, TBL[r][4:2]});
      check($sformatf("%s row %0d {full,empty}", row_tag(r), r),
            {30'd0, full, empty}, {30'd0, TBL[r][1:0]});
    end

    // R8: remove from empty is flagged once and changes nothing
    @(negedge clk);
    {ins_valid, rem_valid, s1_vld, s2_vld, s3_vld} = 5'b01000;
    #1;
    check("R8 no flag before edge", {31'd0, rem_err}, 32'd0);
    @(negedge clk);
    rem_valid = 1'b0;
    #1;
    check("R8 flag after empty remove", {31'd0, rem_err}, 32'd1);
    check("R8 still empty", {31'd0, empty}, 32'd1);
    @(negedge clk);
    #1;
    check("R8 flag lasts one cycle", {31'd0, rem_err}, 32'd0);

    // R1: reset while holding entries
    @(negedge clk);
    ins_valid = 1'b1; ins_dst_vld = 1'b1; ins_dst_idx = 5'd4;
    @(negedge clk);
    ins_dst_idx = 5'd6;
    @(negedge clk);
    ins_valid = 1'b0; s1_vld = 1'b1; s1_idx = 5'd4; s2_vld = 1'b1; s2_idx = 5'd6;
    #1;
    check("R1 full before reset", {31'd0, full}, 32'd1);
    check("R2 both held before reset", {30'd0, hit1, hit2}, 32'b11);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 mid-run reset flags {full,empty}", {30'd0, full, empty}, 32'b01);
    check("R1 mid-run reset clears hits", {30'd0, hit1, hit2}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule